// File: doc/BRIEF.md
# Counter Overflow Interrupt Aggregator

This block keeps a free-running up-counter and merges five sticky event flags into one registered interrupt request. Two flags come from the counter itself. One is raised when the whole counter wraps to zero. The other is raised on a carry out of a low slice of the counter, and software picks that slice's width from four choices. The remaining three flags are raised by one-cycle event pulses from external capture/compare channels. Every flag latches whenever its trigger fires. Its enable bit only decides whether the flag feeds the request.

Software drives the block through a small write-only register port. One register holds the run bit, the two global gate bits and the width select. A second register holds the per-flag enables. A third address clears flags with write-one-to-clear semantics. The flag vector and the counter value are outputs, so the surrounding logic can read them.

Top module: `ovf_irq_merge`

## Requirements
- R1: While the run bit (bit 0 of the control register at address 0) is 1, the counter adds one on every clock and wraps modulo 2^16. While the run bit is 0, the counter holds its value.
- R2: The full flag (flags_o bit 0) is set on the clock edge where the counter goes from 16'hFFFF to 0.
- R3: The intermediate flag (flags_o bit 1) is set on the edge where the low W counter bits carry out. W is 8, 9, 10 or 11 for width-select codes 00, 01, 10 and 11, held in control bits [4:3]. A new code applies from the next increment.
- R4: A flag latches its trigger whatever its enable bit is. The flag vector layout is bit 0 full, bit 1 intermediate, bits 2..4 channels 0..2.
- R5: A flag contributes to the request only while its enable bit is 1. The enable register is at address 1 and uses the same bit layout as the flag vector.
- R6: irq_o can be 1 only while both the global enable (control bit 1) and the block enable (control bit 2) are 1.
- R7: A one-cycle pulse on ch_evt_i[n] sets channel flag n (flags_o bit 2+n).
- R8: Writing ones to address 2 clears the matching flags and leaves the other flags alone. A trigger in the same cycle as its clear wins, so that flag stays set.
- R9: irq_o is registered. It rises one cycle after a set flag is enabled, and it falls one cycle after the last enabled flag is cleared.
- R10: A synchronous active-high reset zeroes the counter, all flags, all enables, all control bits and irq_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 control, 1 enables, 2 clear |
| wr_data_i | input | 8 | Register write data |
| ch_evt_i | input | 3 | One-cycle event pulses from the channels |
| irq_o | output | 1 | Registered interrupt request |
| cnt_o | output | 16 | Current counter value |
| flags_o | output | 5 | Sticky event flags |

## Verification
The embedded assertions check the per-cycle relations on every clock: the counter steps or holds, each counter hit and channel pulse leaves its flag set on the next cycle, flags stay sticky, clears work and a trigger beats its clear, and the request stays low whenever a gate bit or the enabled-flag set is empty. Other behaviours depend on counting up to a wrap or across a sequence of register writes, and only the bench scenarios can show them. These are the exact carry positions for each of the four widths, the full 16-bit wrap, and the one-cycle rise and fall of the request around enable writes and clears.

// File: rtl/ovf_irq_pkg.sv
package ovf_irq_pkg;
   // register addresses
   localparam int unsigned ADDR_CTRL = 0;
   localparam int unsigned ADDR_EN   = 1;
   localparam int unsigned ADDR_CLR  = 2;
   // control register bit positions
   localparam int unsigned CTRL_RUN  = 0;
   localparam int unsigned CTRL_GLB  = 1;
   localparam int unsigned CTRL_BLK  = 2;
   localparam int unsigned CTRL_SEL  = 3;
   // flag vector layout
   localparam int unsigned FLG_FULL  = 0;
   localparam int unsigned FLG_MID   = 1;
   localparam int unsigned FLG_CH0   = 2;
endpackage

// File: rtl/ovf_irq_regs.sv
module ovf_irq_regs
   import ovf_irq_pkg::*;
#(
   parameter int unsigned ADDR_W = 2,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned SEL_W  = 2,
   parameter int unsigned NFLAG  = 5
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic              run_o,
   output logic              glb_o,
   output logic              blk_o,
   output logic [SEL_W-1:0]  sel_o,
   output logic [NFLAG-1:0]  en_o,
   output logic [NFLAG-1:0]  clr_o
);
   localparam int unsigned CTRL_BITS = CTRL_SEL + SEL_W;

   if (DATA_W < NFLAG || DATA_W < CTRL_BITS) begin : g_bad_width
      $error("ovf_irq_regs: DATA_W too narrow for register fields");
   end
   if ((1 << ADDR_W) <= ADDR_CLR) begin : g_bad_addr
      $error("ovf_irq_regs: ADDR_W too narrow for register map");
   end

   logic wr_ctrl, wr_en_reg, wr_clr;
   assign wr_ctrl   = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_CTRL));
   assign wr_en_reg = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_EN));
   assign wr_clr    = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_CLR));

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         run_o <= 1'b0;
         glb_o <= 1'b0;
         blk_o <= 1'b0;
         sel_o <= '0;
         en_o  <= '0;
      end else begin
         if (wr_ctrl) begin
            run_o <= wr_data_i[CTRL_RUN];
            glb_o <= wr_data_i[CTRL_GLB];
            blk_o <= wr_data_i[CTRL_BLK];
            sel_o <= wr_data_i[CTRL_SEL +: SEL_W];
         end
         if (wr_en_reg) begin
            en_o <= wr_data_i[NFLAG-1:0];
         end
      end
   end

   assign clr_o = wr_clr ? wr_data_i[NFLAG-1:0] : '0;

   // R5: an enable write is visible on the next cycle
   a_r5_en_load: assert property (@(posedge clk_i) disable iff (rst_i)
      wr_en_reg |=> (en_o == $past(wr_data_i[NFLAG-1:0])));
endmodule

// File: rtl/ovf_irq_counter.sv
module ovf_irq_counter #(
   parameter int unsigned CNT_W    = 16,
   parameter int unsigned SEL_W    = 2,
   parameter int unsigned MID_BASE = 8
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             run_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             full_hit_o,
   output logic             mid_hit_o
);
   localparam int unsigned MID_MAX = MID_BASE + (1 << SEL_W) - 1;

   if (MID_MAX >= CNT_W) begin : g_bad_mid
      $error("ovf_irq_counter: widest intermediate slice must be narrower than counter");
   end
   if (MID_BASE == 0) begin : g_bad_base
      $error("ovf_irq_counter: MID_BASE must be nonzero");
   end

   logic [CNT_W-1:0] mid_mask;
   assign mid_mask = (CNT_W'(1) << (MID_BASE + 32'(sel_i))) - CNT_W'(1);

   assign full_hit_o = run_i && (&cnt_o);
   assign mid_hit_o  = run_i && ((cnt_o & mid_mask) == mid_mask);

   always_ff @(posedge clk_i) begin
      if (rst_i)      cnt_o <= '0;
      else if (run_i) cnt_o <= cnt_o + CNT_W'(1);
   end

   // R1: step by one while running, hold otherwise
   a_r1_step: assert property (@(posedge clk_i) disable iff (rst_i)
      run_i |=> (cnt_o == $past(cnt_o) + CNT_W'(1)));
   a_r1_hold: assert property (@(posedge clk_i) disable iff (rst_i)
      !run_i |=> $stable(cnt_o));
   // R2: a full hit implies a mid hit in the same cycle
   a_r2_full_implies_mid: assert property (@(posedge clk_i) disable iff (rst_i)
      full_hit_o |-> mid_hit_o);
endmodule

// File: rtl/ovf_irq_flags.sv
module ovf_irq_flags #(
   parameter int unsigned NFLAG = 5
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic [NFLAG-1:0] trig_i,
   input  logic [NFLAG-1:0] clr_i,
   output logic [NFLAG-1:0] flag_o
);
   if (NFLAG < 1) begin : g_bad_n
      $error("ovf_irq_flags: NFLAG must be positive");
   end

   for (genvar i = 0; i < NFLAG; i++) begin : g_flag
      always_ff @(posedge clk_i) begin
         if (rst_i) flag_o[i] <= 1'b0;
         else       flag_o[i] <= trig_i[i] | (flag_o[i] & ~clr_i[i]);
      end

      // R8: trigger beats a simultaneous clear
      a_r8_trig_wins: assert property (@(posedge clk_i) disable iff (rst_i)
         trig_i[i] |=> flag_o[i]);
      // R8: a clear without a trigger empties the flag
      a_r8_clear: assert property (@(posedge clk_i) disable iff (rst_i)
         (clr_i[i] && !trig_i[i]) |=> !flag_o[i]);
      // R4: flags are sticky
      a_r4_sticky: assert property (@(posedge clk_i) disable iff (rst_i)
         (flag_o[i] && !clr_i[i]) |=> flag_o[i]);
      // R4: a flag never rises without a trigger
      a_r4_no_spurious: assert property (@(posedge clk_i) disable iff (rst_i)
         (!flag_o[i] && !trig_i[i]) |=> !flag_o[i]);
   end
endmodule

// File: rtl/ovf_irq_merge.sv
module ovf_irq_merge
   import ovf_irq_pkg::*;
#(
   parameter int unsigned CNT_W    = 16,
   parameter int unsigned NUM_CH   = 3,
   parameter int unsigned SEL_W    = 2,
   parameter int unsigned MID_BASE = 8,
   parameter int unsigned ADDR_W   = 2,
   parameter int unsigned DATA_W   = 8
) (
   input  logic                      clk_i,
   input  logic                      rst_i,
   input  logic                      wr_en_i,
   input  logic [ADDR_W-1:0]         wr_addr_i,
   input  logic [DATA_W-1:0]         wr_data_i,
   input  logic [NUM_CH-1:0]         ch_evt_i,
   output logic                      irq_o,
   output logic [CNT_W-1:0]          cnt_o,
   output logic [FLG_CH0+NUM_CH-1:0] flags_o
);
   localparam int unsigned NFLAG = FLG_CH0 + NUM_CH;

   if (NUM_CH < 1) begin : g_bad_ch
      $error("ovf_irq_merge: NUM_CH must be positive");
   end

   logic             run, glb, blk;
   logic [SEL_W-1:0] sel;
   logic [NFLAG-1:0] en, clr, trig;
   logic             full_hit, mid_hit;

   ovf_irq_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W), .NFLAG(NFLAG)
   ) u_regs (
      .clk_i(clk_i), .rst_i(rst_i),
      .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
      .run_o(run), .glb_o(glb), .blk_o(blk), .sel_o(sel),
      .en_o(en), .clr_o(clr)
   );

   ovf_irq_counter #(
      .CNT_W(CNT_W), .SEL_W(SEL_W), .MID_BASE(MID_BASE)
   ) u_cnt (
      .clk_i(clk_i), .rst_i(rst_i), .run_i(run), .sel_i(sel),
      .cnt_o(cnt_o), .full_hit_o(full_hit), .mid_hit_o(mid_hit)
   );

   assign trig[FLG_FULL] = full_hit;
   assign trig[FLG_MID]  = mid_hit;
   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign trig[FLG_CH0 + c] = ch_evt_i[c];

      // R7: a channel pulse leaves its flag set
      a_r7_ch_set: assert property (@(posedge clk_i) disable iff (rst_i)
         ch_evt_i[c] |=> flags_o[FLG_CH0 + c]);
   end

   ovf_irq_flags #(.NFLAG(NFLAG)) u_flags (
      .clk_i(clk_i), .rst_i(rst_i), .trig_i(trig), .clr_i(clr), .flag_o(flags_o)
   );

   always_ff @(posedge clk_i) begin
      if (rst_i) irq_o <= 1'b0;
      else       irq_o <= glb && blk && (|(flags_o & en));
   end

   // R2: full wrap raises the full flag
   a_r2_wrap: assert property (@(posedge clk_i) disable iff (rst_i)
      (run && (&cnt_o)) |=> (flags_o[FLG_FULL] && (cnt_o == '0)));
   // R3: intermediate carry raises the mid flag
   a_r3_mid: assert property (@(posedge clk_i) disable iff (rst_i)
      mid_hit |=> flags_o[FLG_MID]);
   // R6: either gate low keeps the request low next cycle
   a_r6_gate: assert property (@(posedge clk_i) disable iff (rst_i)
      !(glb && blk) |=> !irq_o);
   // R5: no enabled flag keeps the request low next cycle
   a_r5_masked: assert property (@(posedge clk_i) disable iff (rst_i)
      ((flags_o & en) == '0) |=> !irq_o);
   // R9: gated and enabled flag raises the request next cycle
   a_r9_rise: assert property (@(posedge clk_i) disable iff (rst_i)
      (glb && blk && ((flags_o & en) != '0)) |=> irq_o);
endmodule

// File: tb/ovf_irq_merge_test.sv
module ovf_irq_merge_test;
   logic        clk = 1'b0;
   logic        rst;
   logic        wr_en;
   logic [1:0]  wr_addr;
   logic [7:0]  wr_data;
   logic [2:0]  ch_evt;
   logic        irq;
   logic [15:0] cnt;
   logic [4:0]  flags;

   int tests = 0;
   int fails = 0;

   always #5 clk = ~clk;

   ovf_irq_merge uut (
      .clk_i(clk), .rst_i(rst), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
      .wr_data_i(wr_data), .ch_evt_i(ch_evt), .irq_o(irq),
      .cnt_o(cnt), .flags_o(flags)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // called at a negedge; returns at the negedge after the write edge
   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic do_reset();
      rst = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      wr_en = 1'b0; wr_addr = '0; wr_data = '0; ch_evt = '0; rst = 1'b1;
      do_reset();
      chk(cnt == 0 && flags == 0 && irq == 0, "R10 reset state", int'(flags), 0);

      for (int s = 0; s < 4; s++) begin
         automatic int w      = 8 + s;
         automatic int len    = (s == 3) ? 65540 : (1 << w) + 4;
         automatic int e_cnt  = 0;
         automatic int e_mid  = 0;
         automatic int e_full = 0;
         automatic int e_irq  = 0;
         automatic int prev;
         automatic bit mid_exp  = 0;
         automatic bit full_exp = 0;
         do_reset();
         wr(2'd0, 8'(1 | (s << 3)));   // run, gates off, width code s
         prev = cnt;
         for (int c = 0; c < len; c++) begin
            @(negedge clk);
            if (int'(cnt) != ((prev + 1) & 16'hFFFF)) e_cnt++;
            if ((int'(cnt) & ((1 << w) - 1)) == 0) mid_exp = 1;
            if (cnt == 0) full_exp = 1;
            if (flags[1] != mid_exp) e_mid++;
            if (flags[0] != full_exp) e_full++;
            if (irq != 1'b0) e_irq++;
            prev = cnt;
         end
         chk(e_cnt == 0, "R1 counter steps by one", e_cnt, 0);
         chk(e_mid == 0 && mid_exp, "R3 intermediate carry position", e_mid, 0);
         chk(e_full == 0, "R2 full wrap flag", e_full, 0);
         chk(e_irq == 0 && flags[1], "R4 latched while disabled, no request", e_irq, 0);
      end
      chk(flags == 5'b00011, "R2 full flag after 16-bit sweep", int'(flags), 3);

      // stop counting, open both gates, no enables yet
      wr(2'd0, 8'h06);
      prev_hold_check();
      chk(irq == 0, "R5 set flags without enables give no request", irq, 0);

      wr(2'd1, 8'h01);
      chk(irq == 0, "R9 request not yet up in enable cycle", irq, 0);
      @(negedge clk);
      chk(irq == 1, "R5 enabled full flag requests", irq, 1);

      wr(2'd0, 8'h02);
      @(negedge clk);
      chk(irq == 0, "R6 block gate low blocks request", irq, 0);
      wr(2'd0, 8'h04);
      @(negedge clk);
      chk(irq == 0, "R6 global gate low blocks request", irq, 0);
      wr(2'd0, 8'h06);
      @(negedge clk);
      chk(irq == 1, "R6 both gates high pass request", irq, 1);

      wr(2'd2, 8'h01);
      chk(flags == 5'b00010, "R8 clear only the written flag", int'(flags), 2);
      chk(irq == 1, "R9 request still up in clear cycle", irq, 1);
      @(negedge clk);
      chk(irq == 0, "R9 request drops one cycle after clear", irq, 0);

      wr(2'd1, 8'h08);
      ch_evt = 3'b010;
      @(posedge clk);
      @(negedge clk);
      ch_evt = '0;
      chk(flags[3] == 1, "R7 channel 1 pulse sets flag", flags[3], 1);
      chk(irq == 0, "R9 request lags channel flag", irq, 0);
      @(negedge clk);
      chk(irq == 1, "R7 enabled channel flag requests", irq, 1);

      ch_evt = 3'b100;
      @(posedge clk);
      @(negedge clk);
      ch_evt = '0;
      chk(flags[4] == 1, "R4 channel 2 latches while disabled", flags[4], 1);

      ch_evt = 3'b001;
      wr(2'd2, 8'h04);
      ch_evt = '0;
      chk(flags[2] == 1, "R8 trigger wins over clear", flags[2], 1);
      wr(2'd2, 8'h04);
      chk(flags[2] == 0, "R8 clear without trigger", flags[2], 0);

      wr(2'd2, 8'h1F);
      chk(flags == 0, "R8 clear all flags", int'(flags), 0);
      @(negedge clk);
      chk(irq == 0, "R9 request drops after last clear", irq, 0);

      do_reset();
      chk(cnt == 0 && flags == 0 && irq == 0, "R10 reset after activity", int'(cnt), 0);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   task automatic prev_hold_check();
      automatic logic [15:0] held = cnt;
      automatic int e = 0;
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         if (cnt != held) e++;
      end
      chk(e == 0, "R1 counter holds while stopped", e, 0);
   endtask
endmodule